// File: doc/BRIEF.md
# Dual-Input Temperature-Proportional PWM Generator

This block turns two digitised temperature (or fan-request) codes into a slow pulse-width-modulated fan drive bit. The codes are unsigned, with full scale equal to the supply rail. On every clock the larger of the two is chosen. Its distance above a lower window edge sets how many ramp steps of each PWM period the output stays high. Codes below the window stop the fan, and codes above it run the fan flat out. The mapping between the two edges is linear.

The PWM time base is a slow strobe, `tick`, from an external oscillator. Each strobe advances an internal ramp counter, and one full ramp of 102 strobes forms one PWM period. The duty value is captured only at period boundaries, so a period is never cut short. A supervisor outside the block drives `enable`. It raises `force_high` during a fan spin-up interval and counts `period_done` pulses to time that interval.

Top module: `fanpwm_gen`

## Requirements
- R1: The duty value is taken from the larger of `ctl_a` and `ctl_b`. Either input alone can set the duty.
- R2: A larger code at or below 77 gives 0 high steps per period. The output stays low for the whole period unless forced.
- R3: A larger code at or above 179 gives 102 high steps per period. The output stays high for the whole period.
- R4: Each period is exactly 102 strobes long. For a larger code m with 77 < m < 179, the output is high on the first m−77 strobes of the period (for example 128 gives 51 and 102 gives 25).
- R5: While `enable` and `force_high` are both high, `pwm_out` is high whatever the codes are.
- R6: While `enable` is low, `pwm_out` and `period_done` are low and the ramp is held at zero. After `enable` rises, a full 102-strobe period begins, using the codes present when `enable` rose.
- R7: The duty value is captured from the codes present on the clock of the strobe that ends a period (or while disabled). Code changes in the middle of a period have no effect until the next period.
- R8: `period_done` is high for exactly the one clock on which the final strobe of a period is accepted, and at no other time.
- R9: On clocks without `tick`, the ramp and `pwm_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Run control. Low forces the output low and clears the ramp |
| force_high | input | 1 | Holds the output high while enabled |
| ctl_a | input | 8 | First control code, 255 = supply rail |
| ctl_b | input | 8 | Second control code, 255 = supply rail |
| tick | input | 1 | One-clock time-base strobe that advances the ramp |
| pwm_out | output | 1 | PWM fan drive bit |
| period_done | output | 1 | One-clock pulse at the end of each PWM period |

## Verification
The assertions assume that `tick` is a single-clock strobe sampled synchronously with `clk`. They also assume that `enable` and `force_high` change only between clock edges and never glitch within a cycle. The stimulus drives every input a short delay after the rising edge and spaces strobes one idle clock apart. Control codes are changed only at well-defined points of a period: just before its last strobe to set the next period, in the middle to check that mid-period changes are ignored, and while disabled. As a result, each measured period has a single expected high-step count that can be worked out from the codes.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_FORCE = 2'd1,
    DRV_PWM   = 2'd2
  } drive_sel_t;

endpackage

// File: rtl/fanpwm_duty_map.sv
module fanpwm_duty_map #(
  parameter int CODE_W  = 8,
  parameter int LO_CODE = 77,
  parameter int HI_CODE = 179,
  parameter int CNT_W   = 7
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CNT_W-1:0]  duty
);

  localparam int SPAN = HI_CODE - LO_CODE;

  logic [CODE_W-1:0] code_max;
  logic [CODE_W-1:0] code_off;

  // winner of the two inputs
  always_comb begin
    if (code_a >= code_b) code_max = code_a;
    else                  code_max = code_b;
  end

  // offset into the window, clamped at both edges
  always_comb begin
    code_off = code_max - CODE_W'(LO_CODE);
    if (code_max <= CODE_W'(LO_CODE))      duty = '0;
    else if (code_max >= CODE_W'(HI_CODE)) duty = CNT_W'(SPAN);
    else                                   duty = CNT_W'(code_off);
  end

endmodule

// File: rtl/fanpwm_ramp.sv
module fanpwm_ramp #(
  parameter int SPAN  = 102,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] ramp,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SPAN - 1);

  logic [CNT_W-1:0] ramp_nxt;
  logic             at_last;

  assign at_last = (ramp == LAST);
  assign wrap    = run & tick & at_last;

  always_comb begin
    ramp_nxt = ramp;
    if (!run)         ramp_nxt = '0;
    else if (tick) begin
      if (at_last)    ramp_nxt = '0;
      else            ramp_nxt = ramp + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp <= '0;
    else        ramp <= ramp_nxt;
  end

  AST_RAMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp < CNT_W'(SPAN)); // R4
  AST_RAMP_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ramp == '0)); // R6
  AST_RAMP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(ramp)); // R9
  AST_RAMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ramp == '0)); // R8

endmodule

// File: rtl/fanpwm_gen.sv
module fanpwm_gen #(
  parameter int CODE_W  = 8,
  parameter int LO_CODE = 77,
  parameter int HI_CODE = 179
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              force_high,
  input  logic [CODE_W-1:0] ctl_a,
  input  logic [CODE_W-1:0] ctl_b,
  input  logic              tick,
  output logic              pwm_out,
  output logic              period_done
);

  import fanpwm_pkg::*;

  localparam int SPAN  = HI_CODE - LO_CODE;
  localparam int CNT_W = $clog2(SPAN + 1);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CNT_W-1:0] duty_now;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_nxt;
  logic [CNT_W-1:0] ramp;
  logic             wrap;
  logic             duty_load;
  drive_sel_t       drv_sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fanpwm_duty_map #(
    .CODE_W  (CODE_W),
    .LO_CODE (LO_CODE),
    .HI_CODE (HI_CODE),
    .CNT_W   (CNT_W)
  ) u_map (
    .code_a (ctl_a),
    .code_b (ctl_b),
    .duty   (duty_now)
  );

  fanpwm_ramp #(
    .SPAN  (SPAN),
    .CNT_W (CNT_W)
  ) u_ramp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (enable),
    .tick  (tick),
    .ramp  (ramp),
    .wrap  (wrap)
  );

  // duty captured only at a period boundary or while idle
  assign duty_load = !enable | wrap;

  always_comb begin
    duty_nxt = duty_q;
    if (duty_load) duty_nxt = duty_now;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) duty_q <= '0;
    else             duty_q <= duty_nxt;
  end

  always_comb begin
    if (!enable)         drv_sel = DRV_OFF;
    else if (force_high) drv_sel = DRV_FORCE;
    else                 drv_sel = DRV_PWM;
  end

  always_comb begin
    case (drv_sel)
      DRV_FORCE: pwm_out = 1'b1;
      DRV_PWM:   pwm_out = (ramp < duty_q);
      default:   pwm_out = 1'b0;
    endcase
  end

  assign period_done = wrap;

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && !period_done) |=> $stable(duty_q)); // R7
  AST_FORCE_DRIVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && force_high) |-> pwm_out); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |-> (!pwm_out && !period_done)); // R6
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && duty_q == CNT_W'(SPAN)) |-> pwm_out); // R3
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && !force_high && duty_q == '0) |-> !pwm_out); // R2
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    period_done |-> tick); // R8

endmodule

// File: tb/fanpwm_gen_test.sv
module fanpwm_gen_test;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       force_high;
  logic [7:0] ctl_a;
  logic [7:0] ctl_b;
  logic       tick;
  logic       pwm_out;
  logic       period_done;

  int checks;
  int errors;
  int exp_q[$];
  int high_cnt;

  fanpwm_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .force_high  (force_high),
    .ctl_a       (ctl_a),
    .ctl_b       (ctl_b),
    .tick        (tick),
    .pwm_out     (pwm_out),
    .period_done (period_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_high(input int a, input int b, input bit frc);
    int m;
    m = (a > b) ? a : b;
    if (frc)      return 102;
    if (m <= 77)  return 0;
    if (m >= 179) return 102;
    return m - 77;
  endfunction

  // monitor: counts high strobes, compares on each period end
  always @(negedge clk) begin
    if (rst_n) begin
      if (!enable) high_cnt = 0;
      else begin
        if (period_done && !tick) chk(1'b0, "R8 done without strobe", 1, 0);
        if (tick && pwm_out) high_cnt++;
        if (period_done) begin
          if (exp_q.size() == 0) chk(1'b0, "R8 unexpected period end", 1, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(high_cnt == e, "R1/R2/R3/R4/R5/R7 high strobes", high_cnt, e);
          end
          high_cnt = 0;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // drive strobes from index i0 to 101, then set up the next period
  task automatic run(input int i0, input int na, input int nb, input bit nf,
                     input bit scramble);
    for (int i = i0; i < 102; i++) begin
      if (scramble && i == 50) begin
        ctl_a = 8'd255; ctl_b = 8'd200;   // R7 mid-period change
      end
      if (i == 101) begin
        ctl_a = 8'(na); ctl_b = 8'(nb);
      end
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
    force_high = nf;
    exp_q.push_back(exp_high(na, nb, nf));
  endtask

  initial begin
    checks = 0; errors = 0; high_cnt = 0;
    rst_n = 1'b0; enable = 1'b0; force_high = 1'b0;
    ctl_a = 8'd0; ctl_b = 8'd0; tick = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    chk(pwm_out == 1'b0, "R6 reset pwm_out", int'(pwm_out), 0);
    chk(period_done == 1'b0, "R6 reset period_done", int'(period_done), 0);
    step();

    ctl_a = 8'd128; ctl_b = 8'd90;
    exp_q.push_back(exp_high(128, 90, 1'b0));
    step();
    enable = 1'b1;
    step();

    run(0, 90, 150, 1'b0, 1'b0);   // R4 51 measured, next R1 via b
    run(0, 200, 10, 1'b0, 1'b0);   // R1 measured, next R3
    run(0, 77, 60, 1'b0, 1'b0);    // R3 measured, next R2 edge
    run(0, 102, 0, 1'b0, 1'b0);    // R2 measured, next R4 25
    run(0, 0, 179, 1'b0, 1'b0);    // R4 measured, next R3 edge
    run(0, 140, 140, 1'b0, 1'b0);  // R3 measured, next equal codes
    run(0, 0, 0, 1'b1, 1'b1);      // R7 scrambled mid-period, next R5 forced
    run(0, 160, 0, 1'b0, 1'b0);    // R5 measured, next 83

    // R6: disable in the middle of the 83 period
    run(60, 20, 20, 1'b0, 1'b0);   // ends 83 period only if ramp counts 60..101
    for (int i = 0; i < 40; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
    enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick = (i % 2 == 0);
      @(negedge clk);
      chk(pwm_out == 1'b0, "R6 disabled pwm_out", int'(pwm_out), 0);
      chk(period_done == 1'b0, "R6 disabled period_done", int'(period_done), 0);
      step();
    end
    tick = 1'b0;
    exp_q.delete();
    ctl_a = 8'd128; ctl_b = 8'd0;
    exp_q.push_back(exp_high(128, 0, 1'b0));
    step();
    enable = 1'b1;
    step();

    // R9: 50 strobes in, then hold without strobes
    for (int i = 0; i < 50; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
    @(negedge clk);
    chk(pwm_out == 1'b1, "R9 before idle", int'(pwm_out), 1);
    for (int i = 0; i < 20; i++) begin
      step();
      @(negedge clk);
      chk(pwm_out == 1'b1 && period_done == 1'b0, "R9 idle hold",
          int'(pwm_out), 1);
    end
    step();
    run(50, 100, 0, 1'b0, 1'b0);   // R6 restart period 51 completes
    run(0, 0, 0, 1'b0, 1'b0);      // measures 23

    chk(exp_q.size() == 1, "R8 period count", exp_q.size(), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule